// File: doc/BRIEF.md
# Delay-Line Update Scheduler

This block decides when the two delay lines of a delay-locked loop receive new settings. It issues a periodic one-cycle strobe to the reference control loop. It issues a second one-cycle strobe that loads a freshly computed target tap into the slave delay line. The reference interval is a fixed two cycles plus a programmable stretch. The slave interval is taken directly from its field, except that zero stands for the longest interval.

Apart from its timer, the slave line is also refreshed in two other cases: once when the loop first reaches lock, and whenever software pulses a force request. A gate input suppresses every kind of slave refresh. A manual override bypasses the loop entirely and presents a fixed tap chosen by software. The override works whether or not the loop is enabled.

There is no streaming data path. Every pin is plain control or status, sampled on the rising clock edge, with no back-pressure.

Top module: `dll_update_sched`

## Requirements
- R1: While enabled, `ref_upd` pulses once every 2 + `ref_int` cycles. The first pulse appears after the (2 + `ref_int`)-th rising edge with `dll_en` high.
- R2: While enabled, with no other slave cause, `slv_upd` pulses once every P cycles. P equals `slv_int` when that field is nonzero, and 256 when it is zero. The first pulse appears after the P-th enabled edge.
- R3: While enabled, a 0-to-1 change of `locked` produces a slave update on the next edge. The slave interval then restarts, so the next timed update comes P cycles later.
- R4: A one-cycle `slv_force` pulse produces a slave update on the next edge. This holds even while `dll_en` is low.
- R5: While `slv_gate` is 1, no slave update occurs from any cause: timer, lock edge or force. `tap_out` keeps its value.
- R6: While `ovr_en` is 1, `tap_out` equals `ovr_tap` in the same cycle, whatever the state of `dll_en` and `slv_gate`. Code k on the tap bus selects physical tap k+1, so 0 is tap 1 and 63 is tap 64.
- R7: On each slave update, `tap_out` (with `ovr_en` low) takes the `target_tap` value present in the cycle the update was caused. It holds that value until the next update.
- R8: While `dll_en` is 0, both timers are held, and no reference, timed or lock-edge strobe is issued. The lock-edge detector is cleared, so enabling with `locked` already high counts as a lock edge.
- R9: Each strobe is a single-cycle pulse. Causes that coincide in one cycle merge into one pulse.
- R10: A new interval value takes effect only when the matching timer next reloads. The period in progress finishes at its old length.
- R11: After reset both strobes are 0 and `tap_out` is 0 (with `ovr_en` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dll_en | input | 1 | Loop enable |
| ref_int | input | 4 | Reference interval stretch N (period 2+N) |
| slv_int | input | 8 | Slave interval (0 means 256) |
| slv_gate | input | 1 | Blocks all slave updates when 1 |
| slv_force | input | 1 | One-cycle software request for a slave update |
| ovr_en | input | 1 | Manual tap override enable |
| ovr_tap | input | 6 | Manual tap code (k selects tap k+1) |
| locked | input | 1 | Lock status of the loop |
| target_tap | input | 6 | Computed target tap code |
| ref_upd | output | 1 | Reference loop update strobe |
| slv_upd | output | 1 | Slave delay line load strobe |
| tap_out | output | 6 | Tap code driven to the slave delay line |

## Verification
The reference timer is swept over all sixteen stretch values. The slave timer is swept over a spread of interval values that includes 1, mid-range values, 255 and the zero-means-256 case; each sweep compares every cycle against an arithmetic prediction. Together these separate an off-by-one in either period rule and a wrong zero mapping. Lock edges and force pulses are placed mid-interval to show that the interval restarts. They are also placed on a timer hit to show that coincident causes merge into one pulse. Gated runs, disabled runs and override while disabled show which causes each control suppresses or bypasses.

// File: rtl/dus_pkg.sv
package dus_pkg;
  localparam int REF_CFG_W = 4;
  localparam int SLV_CFG_W = 8;
  localparam int TAP_W     = 6;
  localparam int REF_BASE  = 2;

  typedef struct packed {
    logic timer;
    logic lock_edge;
    logic forced;
  } slv_cause_t;
endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CFG_W       = 4,
  parameter bit ZERO_IS_MAX = 1'b0,
  parameter int OFFSET      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg,
  input  logic             restart,
  output logic             hit
);
  localparam int CW = CFG_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] per;
  logic [CW-1:0] next_per;
  logic [CW-1:0] eff_per;
  logic          armed;

  generate
    if (ZERO_IS_MAX) begin : g_zero_max
      assign next_per = (cfg == '0) ? CW'(1 << CFG_W) : CW'(cfg);
    end else begin : g_offset
      assign next_per = CW'(cfg) + CW'(OFFSET);
    end
  endgenerate

  assign eff_per = armed ? per : next_per;
  assign hit     = run && (cnt == eff_per - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per   <= '0;
      armed <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (hit || restart) begin
      cnt   <= '0;
      per   <= next_per;
      armed <= 1'b1;
    end else begin
      cnt <= cnt + CW'(1);
      if (!armed) begin
        per   <= next_per;
        armed <= 1'b1;
      end
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < eff_per));
  assert_idle_counter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/slave_update_ctrl.sv
module slave_update_ctrl
  import dus_pkg::*;
#(
  parameter int TW = TAP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          locked,
  input  logic          force_req,
  input  logic          gate,
  input  logic          timer_hit,
  input  logic [TW-1:0] target_tap,
  output logic          restart,
  output logic          slv_upd,
  output logic [TW-1:0] slv_tap
);
  logic       locked_q;
  slv_cause_t cause;

  always_comb begin
    cause.timer     = timer_hit;
    cause.lock_edge = en && locked && !locked_q;
    cause.forced    = force_req;
  end

  assign restart = (|cause) && !gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      slv_upd  <= 1'b0;
      slv_tap  <= '0;
    end else begin
      locked_q <= en ? locked : 1'b0;
      slv_upd  <= restart;
      if (restart) slv_tap <= target_tap;
    end
  end

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> !slv_upd);
  assert_force_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !gate) |=> slv_upd);
  assert_lock_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $rose(locked) && !gate) |=> slv_upd);
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slv_upd |-> (slv_tap == $past(target_tap)));
endmodule

// File: rtl/tap_select.sv
module tap_select #(
  parameter int TW = 6
) (
  input  logic          ovr_en,
  input  logic [TW-1:0] ovr_tap,
  input  logic [TW-1:0] slv_tap,
  output logic [TW-1:0] tap_out
);
  assign tap_out = ovr_en ? ovr_tap : slv_tap;
endmodule

// File: rtl/dll_update_sched.sv
module dll_update_sched
  import dus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dll_en,
  input  logic [REF_CFG_W-1:0] ref_int,
  input  logic [SLV_CFG_W-1:0] slv_int,
  input  logic                 slv_gate,
  input  logic                 slv_force,
  input  logic                 ovr_en,
  input  logic [TAP_W-1:0]     ovr_tap,
  input  logic                 locked,
  input  logic [TAP_W-1:0]     target_tap,
  output logic                 ref_upd,
  output logic                 slv_upd,
  output logic [TAP_W-1:0]     tap_out
);
  logic             ref_hit;
  logic             slv_hit;
  logic             slv_restart;
  logic [TAP_W-1:0] slv_tap;

  interval_timer #(.CFG_W(REF_CFG_W), .ZERO_IS_MAX(1'b0), .OFFSET(REF_BASE)) u_ref_tmr (
    .clk(clk), .rst_n(rst_n), .run(dll_en), .cfg(ref_int),
    .restart(1'b0), .hit(ref_hit)
  );

  interval_timer #(.CFG_W(SLV_CFG_W), .ZERO_IS_MAX(1'b1), .OFFSET(0)) u_slv_tmr (
    .clk(clk), .rst_n(rst_n), .run(dll_en), .cfg(slv_int),
    .restart(slv_restart), .hit(slv_hit)
  );

  slave_update_ctrl #(.TW(TAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(dll_en), .locked(locked),
    .force_req(slv_force), .gate(slv_gate), .timer_hit(slv_hit),
    .target_tap(target_tap), .restart(slv_restart),
    .slv_upd(slv_upd), .slv_tap(slv_tap)
  );

  tap_select #(.TW(TAP_W)) u_tap (
    .ovr_en(ovr_en), .ovr_tap(ovr_tap), .slv_tap(slv_tap), .tap_out(tap_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_upd <= 1'b0;
    else        ref_upd <= ref_hit;
  end

  assert_ref_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_upd |=> !ref_upd);
  assert_ref_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dll_en |=> !ref_upd);
  assert_slv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dll_en && !slv_force) |=> !slv_upd);
endmodule

// File: tb/sim_dll_update_sched.sv
module sim_dll_update_sched;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dll_en = 1'b0;
  logic [3:0] ref_int = '0;
  logic [7:0] slv_int = '0;
  logic       slv_gate = 1'b0;
  logic       slv_force = 1'b0;
  logic       ovr_en = 1'b0;
  logic [5:0] ovr_tap = '0;
  logic       locked = 1'b0;
  logic [5:0] target_tap = '0;
  logic       ref_upd;
  logic       slv_upd;
  logic [5:0] tap_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_update_sched u0 (
    .clk(clk), .rst_n(rst_n), .dll_en(dll_en), .ref_int(ref_int),
    .slv_int(slv_int), .slv_gate(slv_gate), .slv_force(slv_force),
    .ovr_en(ovr_en), .ovr_tap(ovr_tap), .locked(locked),
    .target_tap(target_tap), .ref_upd(ref_upd), .slv_upd(slv_upd),
    .tap_out(tap_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiesce();
    dll_en = 0; locked = 0; slv_gate = 0; slv_force = 0; ovr_en = 0;
    step(); step();
  endtask

  // R1 sweep: pulses exactly at multiples of 2+N
  task automatic sweep_ref(input int n);
    int bad = 0;
    int per = n + 2;
    quiesce();
    ref_int = 4'(n); slv_int = 8'd0;
    dll_en = 1;
    for (int j = 1; j <= 3 * per; j++) begin
      step();
      if (ref_upd !== ((j % per) == 0)) bad++;
    end
    chk(bad == 0, $sformatf("R1 ref period N=%0d", n), bad, 0);
  endtask

  // R2 sweep: zero maps to 256
  task automatic sweep_slv(input int v);
    int bad = 0;
    int per = (v == 0) ? 256 : v;
    quiesce();
    slv_int = 8'(v); ref_int = 4'd0;
    dll_en = 1;
    for (int j = 1; j <= 2 * per + 3; j++) begin
      step();
      if (slv_upd !== ((j % per) == 0)) bad++;
    end
    chk(bad == 0, $sformatf("R2 slave period cfg=%0d", v), bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    int cnt;
    step(); step();
    rst_n = 1;
    step();
    // R11 reset state
    chk(ref_upd == 0 && slv_upd == 0, "R11 strobes after reset", {ref_upd, slv_upd}, 0);
    chk(tap_out == 0, "R11 tap after reset", tap_out, 0);

    for (int n = 0; n < 16; n++) sweep_ref(n);
    sweep_slv(1); sweep_slv(2); sweep_slv(3); sweep_slv(7);
    sweep_slv(15); sweep_slv(100); sweep_slv(255); sweep_slv(0);

    // R3 + R7: lock edge mid-interval restarts; captures target
    quiesce();
    slv_int = 8'd20; dll_en = 1; bad = 0;
    target_tap = 6'h2A;
    for (int j = 1; j <= 30; j++) begin
      if (j == 6) locked = 1;
      if (j == 8) target_tap = 6'h11;
      step();
      if (slv_upd !== (j == 6 || j == 26)) bad++;
      if (j == 6) chk(tap_out == 6'h2A, "R7 capture on lock update", tap_out, 6'h2A);
      if (j == 25) chk(tap_out == 6'h2A, "R7 tap held between updates", tap_out, 6'h2A);
      if (j == 26) chk(tap_out == 6'h11, "R7 capture on timed update", tap_out, 6'h11);
    end
    chk(bad == 0, "R3 lock edge update and restart", bad, 0);

    // R4: force mid-interval restarts the interval
    quiesce();
    slv_int = 8'd20; dll_en = 1; bad = 0;
    for (int j = 1; j <= 30; j++) begin
      slv_force = (j == 4);
      step();
      if (slv_upd !== (j == 4 || j == 24)) bad++;
    end
    slv_force = 0;
    chk(bad == 0, "R4 force update while enabled", bad, 0);

    // R4: force works while disabled
    quiesce();
    target_tap = 6'h05; slv_force = 1;
    step();
    slv_force = 0;
    chk(slv_upd == 1 && tap_out == 6'h05, "R4 force while disabled", {slv_upd, tap_out}, {1'b1, 6'h05});
    step();
    chk(slv_upd == 0, "R9 force pulse is single cycle", slv_upd, 0);

    // R5: gate blocks timer, lock edge and force
    quiesce();
    target_tap = 6'h33; slv_int = 8'd4; slv_gate = 1; dll_en = 1; bad = 0;
    for (int j = 1; j <= 20; j++) begin
      locked = (j >= 5);
      slv_force = (j == 9);
      step();
      if (slv_upd !== 1'b0) bad++;
    end
    slv_force = 0;
    chk(bad == 0, "R5 gate blocks all slave causes", bad, 0);
    chk(tap_out == 6'h05, "R5 tap kept under gate", tap_out, 6'h05);

    // R6: override while disabled and gated, both ends of the code range
    quiesce();
    slv_gate = 1; ovr_en = 1; ovr_tap = 6'h3F;
    #1;
    chk(tap_out == 6'h3F, "R6 override tap 64 while disabled", tap_out, 6'h3F);
    ovr_tap = 6'h00;
    #1;
    chk(tap_out == 6'h00, "R6 override tap 1", tap_out, 0);
    ovr_en = 0;
    #1;
    chk(tap_out == 6'h05, "R6 release returns slave tap", tap_out, 6'h05);

    // R8: disabled with locked high: quiet; enabling counts as a lock edge
    quiesce();
    ref_int = 4'd0; slv_int = 8'd1; locked = 1; cnt = 0;
    for (int j = 0; j < 30; j++) begin
      step();
      if (ref_upd || slv_upd) cnt++;
    end
    chk(cnt == 0, "R8 no strobes while disabled", cnt, 0);
    slv_int = 8'd50; target_tap = 6'h2C; dll_en = 1;
    step();
    chk(slv_upd == 1 && tap_out == 6'h2C, "R8 enable with lock high updates", {slv_upd, tap_out}, {1'b1, 6'h2C});

    // R9: lock edge + force + timer hit in one cycle merge
    quiesce();
    slv_int = 8'd10; dll_en = 1; bad = 0;
    for (int j = 1; j <= 21; j++) begin
      locked = (j >= 10);
      slv_force = (j == 10);
      step();
      if (slv_upd !== (j == 10 || j == 20)) bad++;
    end
    slv_force = 0;
    chk(bad == 0, "R9 coincident causes give one pulse", bad, 0);

    // R10: interval change takes effect at next reload
    quiesce();
    ref_int = 4'd2; dll_en = 1; bad = 0;
    for (int j = 1; j <= 21; j++) begin
      step();
      if (j == 2) ref_int = 4'd6;
      if (ref_upd !== (j == 4 || j == 12 || j == 20)) bad++;
    end
    chk(bad == 0, "R10 ref interval change at reload", bad, 0);

    quiesce();
    slv_int = 8'd5; dll_en = 1; bad = 0;
    for (int j = 1; j <= 16; j++) begin
      step();
      if (j == 1) slv_int = 8'd3;
      if (slv_upd !== (j == 5 || j == 8 || j == 11 || j == 14)) bad++;
    end
    chk(bad == 0, "R10 slave interval change at reload", bad, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule